// File: doc/BRIEF.md
# Overpower Fault Integrating Timer

This block turns a per-cycle overload verdict into a latched overpower fault for a switching power controller. An external comparator reports whether the feedback level sits above a ramp derived from the switch on-time. The block reads that verdict once per switching cycle, at the falling edge of the internal PWM signal, and the verdict sets the direction of an accumulator. The accumulator then steps on a free-running timebase: up while the last verdict was overload, down while it was normal load. Short overload bursts therefore add up instead of restarting a timeout, and a boost that is shorter than the quiet interval after it is forgiven.

When the accumulator reaches its terminal count (85 ms at the default tick of 1 us from a 250 MHz clock), the block latches a fault and drops the switching-enable output to the gate-drive path. It stays in that state until a synchronous clear request or the asynchronous reset. The running count is brought out so that accumulation can be observed.

Top module: `ovl_integ_timer`

## Requirements
- R1: `pwm_i` passes through a two-stage synchroniser. If `pwm_i` is sampled high at clock edge n-1 and low at edge n, `ovl_i` is sampled at edge n+2 and sets the direction: 1 means up, 0 means down. At every other edge `ovl_i` has no effect.
- R2: The count changes only on tick edges. A tick falls every TICK_DIV clock edges. The first tick is the TICK_DIV-th edge after reset release or after a clear.
- R3: With the direction up and no fault, each tick raises `cnt_o` by exactly 1.
- R4: With the direction down, each tick lowers `cnt_o` by 1, and the count holds at 0 instead of wrapping. Reset and clear both leave the direction down.
- R5: `fault_o` rises at the same edge at which `cnt_o` reaches LIMIT, and `sw_en_o` is always the inverse of `fault_o`.
- R6: Once set, `fault_o` stays 1 and `cnt_o` stays at LIMIT whatever `pwm_i` and `ovl_i` do, until a clear or a reset.
- R7: When `clr_i` is sampled high at an edge, that edge zeroes the count, the fault, the direction (down) and the tick phase, taking priority over any other update.
- R8: While `rst_ni` is low, `cnt_o` is 0, `fault_o` is 0 and `sw_en_o` is 1, and this takes effect without waiting for a clock edge.
- R9: Overload bursts that are each shorter than LIMIT ticks still set the fault when every burst outlasts the normal interval that follows it. Bursts shorter than the normal interval that follows them never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Internal PWM signal; its falling edge samples the verdict |
| ovl_i | input | 1 | Comparator verdict: feedback above the on-time ramp |
| clr_i | input | 1 | Synchronous fault-clear request |
| fault_o | output | 1 | Latched overpower fault |
| sw_en_o | output | 1 | Switching enable to the gate drive, low during a fault |
| cnt_o | output | $clog2(LIMIT+1) | Accumulated overload count |

## Verification
A direction latched at the wrong moment or from the wrong edge moves `cnt_o` the wrong way. This shows on the very next tick, at most TICK_DIV cycles later. A wrong tick phase or step size makes `cnt_o` differ from a cycle-accurate reference model within one tick. Errors in saturation or in the fault latch show as a wrapped count, an early or late `fault_o`, or a `sw_en_o` that comes back on its own, each at the first edge where the state goes wrong. Because the bench compares every output at every cycle, each of these faults is caught within one tick period.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } ovl_dir_e;
endpackage

// File: rtl/ovl_pwm_edge.sv
`timescale 1ns/1ps
module ovl_pwm_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic fall_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= pwm_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign fall_o = prev_q & ~sync_q[LAST];

  // R1
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ovl_tick_gen.sv
`timescale 1ns/1ps
module ovl_tick_gen #(
  parameter int unsigned TICK_DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  if (TICK_DIV <= 1) begin : g_every
    assign tick_o = 1'b1;
  end else begin : g_div
    localparam int unsigned PRE_W = $clog2(TICK_DIV);
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick_o = (pre_q == PRE_TOP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              pre_q <= '0;
      else if (clr_i || tick_o) pre_q <= '0;
      else                      pre_q <= pre_q + 1'b1;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/ovl_acc.sv
`timescale 1ns/1ps
module ovl_acc
  import ovl_pkg::*;
#(
  parameter int unsigned LIMIT = 85000,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             ovl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fault_o
);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(LIMIT - 1);

  ovl_dir_e         dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
      dir_q   <= DIR_DOWN;
    end else if (clr_i) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
      dir_q   <= DIR_DOWN;
    end else begin
      if (fall_i) dir_q <= ovl_i ? DIR_UP : DIR_DOWN;
      if (tick_i && !fault_q) begin
        if (dir_q == DIR_UP) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_PRE) fault_q <= 1'b1;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign fault_o = fault_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  // R4
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && dir_q == DIR_DOWN && !fall_i) |=> (cnt_q == '0));
  // R5
  fault_at_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> (cnt_q == CNT_TOP));
  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_TOP);
  // R6
  fault_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !clr_i) |=> (fault_q && $stable(cnt_q)));
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !fault_q && dir_q == DIR_DOWN));
endmodule

// File: rtl/ovl_integ_timer.sv
`timescale 1ns/1ps
module ovl_integ_timer #(
  parameter int unsigned TICK_DIV    = 250,
  parameter int unsigned LIMIT       = 85000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pwm_i,
  input  logic                         ovl_i,
  input  logic                         clr_i,
  output logic                         fault_o,
  output logic                         sw_en_o,
  output logic [$clog2(LIMIT+1)-1:0]   cnt_o
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic fall;
  logic tick;
  logic fault;

  ovl_pwm_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_i  (pwm_i),
    .fall_o (fall)
  );

  ovl_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .tick_o (tick)
  );

  ovl_acc #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .tick_i  (tick),
    .fall_i  (fall),
    .ovl_i   (ovl_i),
    .cnt_o   (cnt_o),
    .fault_o (fault)
  );

  assign fault_o = fault;
  assign sw_en_o = ~fault;

  // R5
  enable_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o != fault_o);
  // R6
  enable_stays_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_en_o && !clr_i) |=> !sw_en_o);
endmodule

// File: tb/sim_ovl_integ_timer.sv
`timescale 1ns/1ps
module sim_ovl_integ_timer;
  localparam int TD  = 4;
  localparam int LIM = 20;
  localparam int CW  = $clog2(LIM + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pwm_i = 1'b0;
  logic          ovl_i = 1'b0;
  logic          clr_i = 1'b0;
  logic          fault_o;
  logic          sw_en_o;
  logic [CW-1:0] cnt_o;

  int  n_run = 0;
  int  n_fail = 0;
  bit  pwm_run = 1'b0;
  bit  done = 1'b0;

  typedef struct {
    int cnt;
    bit flt;
    bit up;
  } exp_t;
  exp_t q[$];

  int      m_pre = 0;
  int      m_cnt = 0;
  bit      m_flt = 1'b0;
  bit      m_dir = 1'b0;
  bit [3:0] ps = '0;

  ovl_integ_timer #(.TICK_DIV(TD), .LIMIT(LIM)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .pwm_i   (pwm_i),
    .ovl_i   (ovl_i),
    .clr_i   (clr_i),
    .fault_o (fault_o),
    .sw_en_o (sw_en_o),
    .cnt_o   (cnt_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // reference model: one expected item per clock edge
  always @(posedge clk) begin
    exp_t e;
    bit tk, fl, nd;
    if (!rst_ni) begin
      m_pre = 0; m_cnt = 0; m_flt = 1'b0; m_dir = 1'b0; ps = '0;
    end else begin
      tk = (m_pre == TD - 1);
      fl = ps[2] & ~ps[1];
      ps = {ps[2:0], pwm_i};
      if (clr_i) begin
        m_pre = 0; m_cnt = 0; m_flt = 1'b0; m_dir = 1'b0;
      end else begin
        nd = fl ? ovl_i : m_dir;
        m_pre = tk ? 0 : m_pre + 1;
        if (tk && !m_flt) begin
          if (m_dir) begin
            if (m_cnt == LIM - 1) m_flt = 1'b1;
            m_cnt = m_cnt + 1;
          end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
          end
        end
        m_dir = nd;
      end
    end
    e.cnt = m_cnt; e.flt = m_flt; e.up = m_dir;
    q.push_back(e);
  end

  // monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      if (rst_ni) begin
        chk(e.up ? "R3" : "R4", int'(cnt_o), e.cnt);
        chk("R5", int'(fault_o), int'(e.flt));
        chk("R5", int'(sw_en_o), int'(!e.flt));
      end
    end
  end

  // PWM source: period 10 cycles, high 4
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      if (pwm_run) begin
        ph = (ph + 1) % 10;
        pwm_i = (ph < 4);
      end else begin
        pwm_i = 1'b0;
      end
    end
  end

  initial begin
    #(4 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear();
    @(posedge clk); #1 clr_i = 1'b1;
    @(posedge clk); #1 clr_i = 1'b0;
  endtask

  initial begin
    int k;
    bit seen;
    cycles(5);
    @(negedge clk);
    // R8: state held by reset
    chk("R8", int'(cnt_o), 0);
    chk("R8", int'(fault_o), 0);
    chk("R8", int'(sw_en_o), 1);
    cycles(1); rst_ni = 1'b1;

    // R4: normal load from zero stays at zero
    pwm_run = 1'b1; ovl_i = 1'b0;
    cycles(100);
    @(negedge clk); chk("R4", int'(cnt_o), 0);

    // R1: verdict changes with no PWM falls are ignored
    pwm_run = 1'b0;
    cycles(20);
    ovl_i = 1'b1;
    cycles(60);
    @(negedge clk); chk("R1", int'(cnt_o), 0);

    // R2/R3: tick spacing while overloaded
    pwm_run = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (cnt_o != 3 && k < 1000);
    k = 0;
    do begin @(negedge clk); k++; end while (cnt_o == 3 && k < 1000);
    chk("R2", k, TD);
    chk("R3", int'(cnt_o), 4);

    // R5: continuous overload reaches the limit
    cycles(120);
    @(negedge clk);
    chk("R5", int'(fault_o), 1);
    chk("R5", int'(sw_en_o), 0);
    chk("R5", int'(cnt_o), LIM);

    // R6: fault holds while verdict toggles
    for (int i = 0; i < 10; i++) begin
      ovl_i = ~ovl_i;
      cycles(7);
    end
    @(negedge clk);
    chk("R6", int'(fault_o), 1);
    chk("R6", int'(cnt_o), LIM);

    // R7: clear
    pulse_clear();
    @(negedge clk);
    chk("R7", int'(cnt_o), 0);
    chk("R7", int'(fault_o), 0);
    chk("R7", int'(sw_en_o), 1);

    // R4: down count back to zero and saturate
    ovl_i = 1'b1; cycles(40);
    ovl_i = 1'b0; cycles(150);
    @(negedge clk); chk("R4", int'(cnt_o), 0);

    // R9: long bursts, short gaps -> fault
    for (int r = 0; r < 8; r++) begin
      ovl_i = 1'b1; cycles(60);
      ovl_i = 1'b0; cycles(40);
    end
    @(negedge clk); chk("R9", int'(fault_o), 1);

    pulse_clear();
    cycles(200);
    // R9: short boosts, long gaps -> never a fault
    seen = 1'b0;
    for (int r = 0; r < 8; r++) begin
      ovl_i = 1'b1;
      repeat (40) begin @(negedge clk); seen |= fault_o; end
      ovl_i = 1'b0;
      repeat (60) begin @(negedge clk); seen |= fault_o; end
    end
    chk("R9", int'(seen), 0);

    // R8: asynchronous reset out of a fault
    ovl_i = 1'b1; cycles(150);
    @(negedge clk); chk("R5", int'(fault_o), 1);
    @(posedge clk); #1 rst_ni = 1'b0;
    #0.5;
    chk("R8", int'(fault_o), 0);
    chk("R8", int'(cnt_o), 0);
    chk("R8", int'(sw_en_o), 1);
    cycles(3); rst_ni = 1'b1;
    cycles(20);
    finish_run();
  end
endmodule